// File: doc/BRIEF.md
# Convergence-Frame Path Error Monitor

This block watches the receive byte stream of a cell-carrying physical-layer convergence frame after alignment has been found. Each byte arrives with a valid qualifier, a frame strobe on the first byte of a frame, and a row strobe on the first byte of every row. Position marks identify the two alignment bytes, the path overhead identifier byte, the parity byte and the status byte. Alignment search and overhead extraction are handled by neighbouring logic.

Three saturating counters are kept: framing-word errors, BIP-8 parity errors and far-end (remote) error indications. The BIP-8 of one frame covers every byte except the three framing bytes of each row. That result is compared against the parity byte carried in the following frame. Run-time configuration selects per-bit or per-word framing counting, enables checking of the identifier byte, and selects per-bit or per-block parity counting.

Software-facing logic reads the counts with a single latch strobe. The strobe copies all three counters into holding registers and restarts them, and no error arriving in that same cycle is lost.

Top module: `plcp_perf_mon`

## Requirements
- R1: The parity result of a frame is the XOR of every valid byte between one frame strobe and the next, except bytes marked as an alignment or identifier byte. It is compared with the parity-marked byte of the next frame.
- R2: With `cfg_block_bip` low, the parity counter grows by the number of differing bits between the parity byte and the stored result, 0 to 8 per frame.
- R3: With `cfg_block_bip` high, the parity counter grows by 1 when any bit differs, and by 0 otherwise.
- R4: On a status-marked byte, the remote counter grows by the value of bits 7:4 when that value is 0 to 8. Values 9 to 15 add nothing.
- R5: With `cfg_word_fe` high, a row adds at most 1 to the framing counter. It adds 1 when any checked word differs from its expected value: alignment byte 1 = F6h, alignment byte 2 = 28h, identifier as in R8.
- R6: With `cfg_word_fe` low, every checked framing byte adds the count of its bits that differ from the expected value.
- R7: With `cfg_poi_en` low, the identifier byte never adds to the framing counter.
- R8: Rows are numbered from 0 at the frame strobe, and the number rises on each later row strobe, holding at ROWS-1. For row r, let k = ROWS-1-r. The expected identifier is {2'b00, k[4:0], p}, where p gives the byte an odd number of ones.
- R9: No parity comparison is made in the first frame after reset or after `lof` has been high. `lof` high suspends all counting.
- R10: Each counter saturates at all ones.
- R11: A cycle with `rd_latch` high copies all counters into `held_*`. The counters restart from that same cycle's increment. `held_*` changes only on `rd_latch`.
- R12: After reset all counters and `held_*` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte qualifier |
| in_byte | input | 8 | Received byte |
| frame_start | input | 1 | First byte of a frame |
| row_start | input | 1 | First byte of a row |
| lof | input | 1 | Loss of frame; suspends counting and clears parity history |
| mark_fa1 | input | 1 | Byte is alignment byte 1 |
| mark_fa2 | input | 1 | Byte is alignment byte 2 |
| mark_poi | input | 1 | Byte is the path overhead identifier |
| mark_par | input | 1 | Byte is the parity byte |
| mark_sts | input | 1 | Byte is the status byte (remote count in bits 7:4) |
| cfg_word_fe | input | 1 | 1: per-word framing count, 0: per-bit |
| cfg_poi_en | input | 1 | Enable identifier checking |
| cfg_block_bip | input | 1 | 1: per-block parity count, 0: per-bit |
| rd_latch | input | 1 | Latch-and-restart strobe |
| held_fe | output | CW | Latched framing error count |
| held_bip | output | CW | Latched parity error count |
| held_rei | output | CW | Latched remote error count |

## Verification
The bench builds the block with CW = 6 and ROWS = 4. The narrow counters let ten frames that each report 8 remote errors drive a counter into saturation at 63. The four-row frame keeps the identifier sequence short, so every row value is checked in each frame. With a small frame, dozens of random frames fit in the run, with the modes switched between frames.

// File: rtl/plcp_pm_pkg.sv
package plcp_pm_pkg;
   localparam int          INC_W   = 4;
   localparam int          N_CNT   = 3;
   localparam int          IDX_FE  = 0;
   localparam int          IDX_BIP = 1;
   localparam int          IDX_REI = 2;
   localparam logic [7:0]  FA1_PAT = 8'hF6;
   localparam logic [7:0]  FA2_PAT = 8'h28;
   localparam logic [3:0]  REI_MAX = 4'd8;

   function automatic logic [INC_W-1:0] ones8(input logic [7:0] v);
      logic [INC_W-1:0] n;
      n = '0;
      for (int i = 0; i < 8; i++) n = n + {{(INC_W-1){1'b0}}, v[i]};
      return n;
   endfunction

   // identifier for countdown value k: k in bits 5:1, odd-parity bit in bit 0
   function automatic logic [7:0] poi_code(input int unsigned k);
      logic [4:0] kk;
      kk = k[4:0];
      return {2'b00, kk, ~^kk};
   endfunction
endpackage

// File: rtl/plcp_bip_track.sv
module plcp_bip_track
   import plcp_pm_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vld,
   input  logic             lof,
   input  logic             frame_start,
   input  logic             excl,
   input  logic             mark_par,
   input  logic [7:0]       in_byte,
   input  logic             block_mode,
   output logic [INC_W-1:0] inc
);
   logic [7:0] acc_q, prev_q, contrib, diff;
   logic       in_frame_q, prev_ok_q;

   assign contrib = excl ? 8'h00 : in_byte;
   assign diff    = in_byte ^ prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q      <= '0;
         prev_q     <= '0;
         in_frame_q <= 1'b0;
         prev_ok_q  <= 1'b0;
      end else if (lof) begin
         in_frame_q <= 1'b0;
         prev_ok_q  <= 1'b0;
      end else if (vld) begin
         if (frame_start) begin
            in_frame_q <= 1'b1;
            acc_q      <= contrib;
            if (in_frame_q) begin
               prev_q    <= acc_q;
               prev_ok_q <= 1'b1;
            end
         end else begin
            acc_q <= acc_q ^ contrib;
         end
      end
   end

   always_comb begin
      inc = '0;
      if (vld && mark_par && prev_ok_q)
         inc = block_mode ? {{(INC_W-1){1'b0}}, |diff} : ones8(diff);
   end
endmodule

// File: rtl/plcp_frame_check.sv
module plcp_frame_check
   import plcp_pm_pkg::*;
#(
   parameter int ROWS = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vld,
   input  logic             frame_start,
   input  logic             row_start,
   input  logic             mark_fa1,
   input  logic             mark_fa2,
   input  logic             mark_poi,
   input  logic [7:0]       in_byte,
   input  logic             word_mode,
   input  logic             poi_en,
   output logic [INC_W-1:0] inc
);
   localparam int RW = (ROWS > 2) ? $clog2(ROWS) : 1;
   localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);

   logic [7:0]    poi_tab [ROWS];
   logic [RW-1:0] row_q, row_cur;
   logic          flag_q, already;
   logic [7:0]    diff;

   for (genvar r = 0; r < ROWS; r++) begin : g_poi
      assign poi_tab[r] = poi_code(ROWS - 1 - r);
   end

   always_comb begin
      if (frame_start)                        row_cur = '0;
      else if (row_start && row_q != ROW_LAST) row_cur = row_q + 1'b1;
      else                                    row_cur = row_q;
   end

   assign already = row_start ? 1'b0 : flag_q;

   always_comb begin
      if (mark_fa1)                  diff = in_byte ^ FA1_PAT;
      else if (mark_fa2)             diff = in_byte ^ FA2_PAT;
      else if (mark_poi && poi_en)   diff = in_byte ^ poi_tab[row_cur];
      else                           diff = 8'h00;
   end

   always_comb begin
      inc = '0;
      if (vld) begin
         if (word_mode) inc = {{(INC_W-1){1'b0}}, (|diff) & ~already};
         else           inc = ones8(diff);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_q  <= '0;
         flag_q <= 1'b0;
      end else if (vld) begin
         row_q  <= row_cur;
         flag_q <= already | (|diff);
      end
   end
endmodule

// File: rtl/plcp_sat_cnt.sv
module plcp_sat_cnt #(
   parameter int CW = 16,
   parameter int IW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [IW-1:0] inc,
   input  logic          latch,
   output logic [CW-1:0] cnt,
   output logic [CW-1:0] held
);
   localparam logic [CW:0] TOP = {1'b0, {CW{1'b1}}};

   logic [CW-1:0] base;
   logic [CW:0]   sum;

   assign base = latch ? '0 : cnt;
   assign sum  = {1'b0, base} + {{(CW+1-IW){1'b0}}, inc};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         held <= '0;
      end else begin
         cnt <= (sum > TOP) ? TOP[CW-1:0] : sum[CW-1:0];
         if (latch) held <= cnt;
      end
   end
endmodule

// File: rtl/plcp_perf_mon.sv
module plcp_perf_mon
   import plcp_pm_pkg::*;
#(
   parameter int CW   = 16,
   parameter int ROWS = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [7:0]    in_byte,
   input  logic          frame_start,
   input  logic          row_start,
   input  logic          lof,
   input  logic          mark_fa1,
   input  logic          mark_fa2,
   input  logic          mark_poi,
   input  logic          mark_par,
   input  logic          mark_sts,
   input  logic          cfg_word_fe,
   input  logic          cfg_poi_en,
   input  logic          cfg_block_bip,
   input  logic          rd_latch,
   output logic [CW-1:0] held_fe,
   output logic [CW-1:0] held_bip,
   output logic [CW-1:0] held_rei
);
   if (CW < INC_W || CW > 32) begin : g_bad_cw
      $error("plcp_perf_mon: CW must lie in 4..32");
   end
   if (ROWS < 2 || ROWS > 32) begin : g_bad_rows
      $error("plcp_perf_mon: ROWS must lie in 2..32");
   end

   logic             vld;
   logic [3:0]       nib;
   logic [INC_W-1:0] inc_vec  [N_CNT];
   logic [CW-1:0]    cnt_vec  [N_CNT];
   logic [CW-1:0]    held_vec [N_CNT];
   logic [CW-1:0]    cnt_fe, cnt_bip, cnt_rei;

   assign vld = in_valid & ~lof;
   assign nib = in_byte[7:4];

   plcp_frame_check #(.ROWS(ROWS)) u_fchk (
      .clk(clk), .rst_n(rst_n), .vld(vld), .frame_start(frame_start),
      .row_start(row_start), .mark_fa1(mark_fa1), .mark_fa2(mark_fa2),
      .mark_poi(mark_poi), .in_byte(in_byte), .word_mode(cfg_word_fe),
      .poi_en(cfg_poi_en), .inc(inc_vec[IDX_FE])
   );

   plcp_bip_track u_bip (
      .clk(clk), .rst_n(rst_n), .vld(vld), .lof(lof), .frame_start(frame_start),
      .excl(mark_fa1 | mark_fa2 | mark_poi), .mark_par(mark_par),
      .in_byte(in_byte), .block_mode(cfg_block_bip), .inc(inc_vec[IDX_BIP])
   );

   assign inc_vec[IDX_REI] = (vld && mark_sts && nib <= REI_MAX) ? nib : '0;

   for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
      plcp_sat_cnt #(.CW(CW), .IW(INC_W)) u_cnt (
         .clk(clk), .rst_n(rst_n), .inc(inc_vec[g]), .latch(rd_latch),
         .cnt(cnt_vec[g]), .held(held_vec[g])
      );
   end

   assign cnt_fe   = cnt_vec[IDX_FE];
   assign cnt_bip  = cnt_vec[IDX_BIP];
   assign cnt_rei  = cnt_vec[IDX_REI];
   assign held_fe  = held_vec[IDX_FE];
   assign held_bip = held_vec[IDX_BIP];
   assign held_rei = held_vec[IDX_REI];
endmodule

// File: rtl/plcp_perf_mon_chk.sv
module plcp_perf_mon_chk #(
   parameter int CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rd_latch,
   input logic          cfg_word_fe,
   input logic          cfg_block_bip,
   input logic [CW-1:0] cnt_fe,
   input logic [CW-1:0] cnt_bip,
   input logic [CW-1:0] cnt_rei,
   input logic [CW-1:0] held_fe,
   input logic [CW-1:0] held_bip,
   input logic [CW-1:0] held_rei
);
   localparam logic [CW-1:0] MAXV = {CW{1'b1}};
   localparam logic [CW-1:0] EIGHT = CW'(8);

   a_r2_bip_step: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_latch |=> cnt_bip >= $past(cnt_bip) && cnt_bip - $past(cnt_bip) <= EIGHT);

   a_r3_block_step: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_block_bip && !rd_latch) |=>
         cnt_bip >= $past(cnt_bip) && cnt_bip - $past(cnt_bip) <= CW'(1));

   a_r4_rei_step: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_latch |=> cnt_rei >= $past(cnt_rei) && cnt_rei - $past(cnt_rei) <= EIGHT);

   a_r5_word_step: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_word_fe && !rd_latch) |=>
         cnt_fe >= $past(cnt_fe) && cnt_fe - $past(cnt_fe) <= CW'(1));

   a_r10_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_rei == MAXV && !rd_latch) |=> cnt_rei == MAXV);

   a_r10_sat_hold_bip: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_bip == MAXV && !rd_latch) |=> cnt_bip == MAXV);

   a_r11_latch_copy: assert property (@(posedge clk) disable iff (!rst_n)
      rd_latch |=> held_fe == $past(cnt_fe) && held_bip == $past(cnt_bip)
                   && held_rei == $past(cnt_rei));

   a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
      rd_latch |=> cnt_rei <= EIGHT && cnt_bip <= EIGHT && cnt_fe <= EIGHT);

   a_r11_held_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_latch |=> $stable(held_fe) && $stable(held_bip) && $stable(held_rei));
endmodule

bind plcp_perf_mon plcp_perf_mon_chk #(.CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_latch(rd_latch), .cfg_word_fe(cfg_word_fe),
   .cfg_block_bip(cfg_block_bip), .cnt_fe(cnt_fe), .cnt_bip(cnt_bip),
   .cnt_rei(cnt_rei), .held_fe(held_fe), .held_bip(held_bip), .held_rei(held_rei)
);

// File: tb/tb_plcp_perf_mon.sv
module tb_plcp_perf_mon;
   localparam int CW    = 6;
   localparam int ROWS  = 4;
   localparam int CELLS = 5;
   localparam int MAXV  = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 0, frame_start = 0, row_start = 0, lof = 0;
   logic [7:0]    in_byte = '0;
   logic          mark_fa1 = 0, mark_fa2 = 0, mark_poi = 0, mark_par = 0, mark_sts = 0;
   logic          cfg_word_fe = 1, cfg_poi_en = 1, cfg_block_bip = 0, rd_latch = 0;
   logic [CW-1:0] held_fe, held_bip, held_rei;

   always #10 clk = ~clk;

   plcp_perf_mon #(.CW(CW), .ROWS(ROWS)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .frame_start(frame_start), .row_start(row_start), .lof(lof),
      .mark_fa1(mark_fa1), .mark_fa2(mark_fa2), .mark_poi(mark_poi),
      .mark_par(mark_par), .mark_sts(mark_sts), .cfg_word_fe(cfg_word_fe),
      .cfg_poi_en(cfg_poi_en), .cfg_block_bip(cfg_block_bip), .rd_latch(rd_latch),
      .held_fe(held_fe), .held_bip(held_bip), .held_rei(held_rei)
   );

   int n_cmp = 0, n_bad = 0;
   int m_fe = 0, m_bip = 0, m_rei = 0, h_fe = 0, h_bip = 0, h_rei = 0;
   int m_row = 0;
   bit m_in_frame = 0, m_prev_ok = 0, m_rowflag = 0;
   logic [7:0] m_acc = 0, m_prev = 0;
   bit done = 0;

   function automatic int pop8(input logic [7:0] v);
      int n = 0;
      for (int i = 0; i < 8; i++) n += v[i];
      return n;
   endfunction

   function automatic logic [7:0] poi_exp(input int r);
      logic [4:0] k;
      k = 5'(ROWS - 1 - r);
      return {2'b00, k, ~^k};
   endfunction

   function automatic int sat(input int v);
      return (v > MAXV) ? MAXV : v;
   endfunction

   task automatic report();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   task automatic check(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, input bit fs, input bit rs,
                            input bit fa1, input bit fa2, input bit poi,
                            input bit par, input bit sts, input bit lat);
      int fi = 0, bi = 0, ri = 0;
      logic [7:0] d;
      @(negedge clk);
      in_valid = 1; in_byte = b; frame_start = fs; row_start = rs;
      mark_fa1 = fa1; mark_fa2 = fa2; mark_poi = poi; mark_par = par;
      mark_sts = sts; rd_latch = lat;
      if (fs) m_row = 0;
      else if (rs && m_row < ROWS - 1) m_row++;
      if (fs) begin
         if (m_in_frame) begin m_prev = m_acc; m_prev_ok = 1; end
         m_in_frame = 1; m_acc = 0;
      end
      if (!(fa1 || fa2 || poi)) m_acc ^= b;
      if (par && m_prev_ok) begin
         d = b ^ m_prev;
         bi = cfg_block_bip ? int'(d != 0) : pop8(d);
      end
      if (sts) ri = (b[7:4] <= 8) ? int'(b[7:4]) : 0;
      if (rs) m_rowflag = 0;
      d = fa1 ? b ^ 8'hF6 : fa2 ? b ^ 8'h28 : (poi && cfg_poi_en) ? b ^ poi_exp(m_row) : 8'h00;
      if (d != 0) begin
         if (cfg_word_fe) begin fi = m_rowflag ? 0 : 1; m_rowflag = 1; end
         else fi = pop8(d);
      end
      if (lat) begin
         h_fe = m_fe; h_bip = m_bip; h_rei = m_rei;
         m_fe = sat(fi); m_bip = sat(bi); m_rei = sat(ri);
      end else begin
         m_fe = sat(m_fe + fi); m_bip = sat(m_bip + bi); m_rei = sat(m_rei + ri);
      end
      @(posedge clk);
   endtask

   task automatic idle_drive();
      in_valid = 0; frame_start = 0; row_start = 0; mark_fa1 = 0; mark_fa2 = 0;
      mark_poi = 0; mark_par = 0; mark_sts = 0; rd_latch = 0;
   endtask

   task automatic latch_check(input string tag);
      @(negedge clk);
      idle_drive(); rd_latch = 1;
      h_fe = m_fe; h_bip = m_bip; h_rei = m_rei; m_fe = 0; m_bip = 0; m_rei = 0;
      @(posedge clk);
      @(negedge clk);
      rd_latch = 0;
      check({tag, " framing"}, int'(held_fe), h_fe);
      check({tag, " parity"}, int'(held_bip), h_bip);
      check({tag, " remote"}, int'(held_rei), h_rei);
   endtask

   task automatic send_frame(input logic [7:0] a1x, input logic [7:0] a2x,
                             input logic [7:0] poix, input logic [7:0] b1m,
                             input logic [3:0] rei, input bit lat_sts);
      for (int r = 0; r < ROWS; r++) begin
         send_byte(8'hF6 ^ (r == 0 ? a1x : 8'h00), r == 0, 1, 1, 0, 0, 0, 0, 0);
         send_byte(8'h28 ^ (r == 0 ? a2x : 8'h00), 0, 0, 0, 1, 0, 0, 0, 0);
         send_byte(poi_exp(r) ^ (r == 2 ? poix : 8'h00), 0, 0, 0, 0, 1, 0, 0, 0);
         if (r == 1)      send_byte(m_prev ^ b1m, 0, 0, 0, 0, 0, 1, 0, 0);
         else if (r == 2) send_byte({rei, 4'($urandom)}, 0, 0, 0, 0, 0, 0, 1, lat_sts);
         else             send_byte(8'($urandom), 0, 0, 0, 0, 0, 0, 0, 0);
         for (int c = 0; c < CELLS; c++) send_byte(8'($urandom), 0, 0, 0, 0, 0, 0, 0, 0);
      end
   endtask

   task automatic lof_pulse();
      @(negedge clk);
      idle_drive(); lof = 1;
      m_in_frame = 0; m_prev_ok = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      lof = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
      end
   end

   initial begin
      void'($urandom(32'd1357));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      // R12: reset state
      check("R12 held_fe", int'(held_fe), 0);
      check("R12 held_bip", int'(held_bip), 0);
      check("R12 held_rei", int'(held_rei), 0);

      // R9: first frame has no parity comparison even with a bad parity byte
      send_frame(0, 0, 0, 8'hFF, 0, 0);
      latch_check("R9 first frame");
      // R1 R2: bit-mode parity over previous frame; R4 remote value 3
      send_frame(0, 0, 0, 8'h0F, 4'd3, 0);
      latch_check("R1 R2 R4 bit parity");
      // R3: block mode
      cfg_block_bip = 1;
      send_frame(0, 0, 0, 8'hFF, 4'd8, 0);
      latch_check("R3 block parity");
      // R5 R8: word mode, two bad words in row 0 and bad identifier in row 2
      send_frame(8'h01, 8'h80, 8'h04, 8'h00, 0, 0);
      latch_check("R5 R8 word framing");
      // R6: bit mode framing
      cfg_word_fe = 0;
      send_frame(8'h03, 8'h00, 8'h10, 8'h00, 0, 0);
      latch_check("R6 bit framing");
      // R7: identifier check disabled
      cfg_poi_en = 0;
      send_frame(8'h00, 8'h00, 8'hFF, 8'h00, 0, 0);
      latch_check("R7 poi disabled");
      cfg_poi_en = 1;
      // R4: out-of-range remote values add nothing
      for (int v = 9; v < 16; v++) send_frame(0, 0, 0, 0, 4'(v), 0);
      latch_check("R4 remote 9..15");
      // R9: after loss of frame no comparison in the next frame
      cfg_block_bip = 0;
      lof_pulse();
      send_frame(0, 0, 0, 8'hFF, 0, 0);
      send_frame(0, 0, 0, 8'h81, 0, 0);
      latch_check("R9 after lof");
      // R11: latch in the same cycle as a remote increment
      send_frame(0, 0, 0, 0, 4'd2, 0);
      send_frame(0, 0, 0, 0, 4'd5, 1);
      check("R11 held at status byte", int'(held_rei), 2);
      latch_check("R11 restart keeps increment");
      // R10: saturation
      for (int i = 0; i < 10; i++) send_frame(0, 0, 0, 8'hFF, 4'd8, 0);
      latch_check("R10 saturate");
      // random mix
      for (int i = 0; i < 40; i++) begin
         cfg_word_fe = 1'($urandom); cfg_poi_en = 1'($urandom); cfg_block_bip = 1'($urandom);
         send_frame(($urandom % 3 == 0) ? 8'($urandom) : 8'h00,
                    ($urandom % 3 == 0) ? 8'($urandom) : 8'h00,
                    ($urandom % 3 == 0) ? 8'($urandom) : 8'h00,
                    ($urandom % 2 == 0) ? 8'($urandom) : 8'h00,
                    4'($urandom), 1'($urandom % 5 == 0));
         if (i % 4 == 3) latch_check("R1 R2 R3 R5 R6 random");
      end
      latch_check("R10 R11 random final");
      done = 1;
      report();
   end
endmodule